// File: doc/BRIEF.md
# External Trigger Exposure Controller

This block runs the exposure sequence of a line-locked image sensor when an external trigger arrives. It counts pixel clocks from each line sync and samples the trigger, the early-readout input and the frame sync once per line, a fixed number of cycles after that sync. A falling trigger edge seen at one of these sample points arms the controller. It then enters trigger mode on a line sync or a frame event, depending on the shutter mode bits. The exposure ends with a one-cycle readout strobe after a programmed number of lines, after a fixed flicker-free line count, after a programmed number of frames, or early on a falling edge of the early-readout input.

The controller drives four control outputs. The busy flag is high for the whole trigger sequence. The discharge request pulses when the exposure starts, so that residual vertical charge can be cleared. The substrate-clear enable is low while charge is being collected. All pins are plain control levels or single-cycle pulses. No data flows through the block, so it has no valid/ready handshake and nothing can push back on it. The vertical clock waveforms and pixel-rate pulses are produced elsewhere from these outputs.

A frame event is a high-to-low change of the active-low frame input between two consecutive sample points.

Top module: `etx_trigger_ctrl`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle after it, busy, xfer_req and flush_req are 0 and sub_clear is 1.
- R2: The trigger, early-readout and frame inputs are sampled only in the cycle whose pixel count equals SAMPLE_POS. The pixel count is 0 in the cycle after a line_sync pulse. An edge is a change from 1 at one sample to 0 at the next. A low glitch that ends between two sample points has no effect.
- R3: Line mode applies when mode_a=0 and either par_sel=0 or mode_b=1. After a trigger edge, exposure starts at the next line_sync. xfer_req pulses for one cycle at the Nth line_sync after the start, where N is exp_count latched at the trigger. A count of 0 behaves like 1.
- R4: Flicker mode applies when par_sel=1, mode_a=0 and mode_b=0. It is line mode with N fixed at FLICKER_LINES.
- R5: Frame mode applies when mode_a=1 and mode_b=0. Exposure starts at the first frame event after the trigger edge, and xfer_req pulses at the Nth frame event after the start.
- R6: When mode_a=1 and mode_b=1, a trigger edge is ignored and busy stays 0.
- R7: busy rises in the cycle after the trigger edge is accepted. It stays high until the first line_sync after the xfer_req pulse. A trigger edge seen while busy is high is ignored.
- R8: flush_req pulses for one cycle when exposure starts, only if flush_en=1 at that edge and the mode is not frame mode.
- R9: During exposure, the first falling edge on early_n ends the exposure. If rdo_sync_sel=0, xfer_req pulses at that sample point. If rdo_sync_sel=1, it pulses at the next frame event. Any further early_n edge in the same sequence, or an edge outside exposure, has no effect.
- R10: In frame mode with exp_count=1 and rdo_sync_sel=1, a trigger edge is ignored.
- R11: sub_clear is 0 from the cycle exposure starts until the xfer_req pulse, and 1 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_sync | input | 1 | One-cycle pulse at the start of each line |
| frame_n | input | 1 | Active-low frame sync level |
| trig_n | input | 1 | Active-low external trigger |
| early_n | input | 1 | Active-low early-readout input |
| mode_a | input | 1 | Shutter mode bit A |
| mode_b | input | 1 | Shutter mode bit B |
| par_sel | input | 1 | 1 = parallel mode select, 0 = serial |
| rdo_sync_sel | input | 1 | 0 = readout on early edge, 1 = readout waits for frame event |
| flush_en | input | 1 | Enables the discharge request at exposure start |
| exp_count | input | CNT_W | Programmed exposure count in lines or frames |
| busy | output | 1 | High during the trigger sequence |
| xfer_req | output | 1 | One-cycle readout strobe |
| flush_req | output | 1 | One-cycle discharge request |
| sub_clear | output | 1 | Substrate-clear enable, low during exposure |

## Verification
Every result is a registered output, so a line_sync, sample point or frame event seen at a clock edge appears on the outputs one cycle later. Trigger acceptance raises busy one cycle after the sample point. Line-timed strobes and the exposure start follow a line_sync edge by one cycle. Frame-timed and early strobes follow the sample point by one cycle. The bench drives inputs on falling edges, advances a behavioural model on each rising edge, and compares every output with the model on the following falling edge. Each scenario also checks its strobe and discharge counts after the sequence has settled.

// File: rtl/etx_pkg.sv
package etx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PEND, ST_EXPOSE, ST_HOLD, ST_DONE
  } etx_state_t;

  typedef enum logic [1:0] {
    CL_LINE, CL_FLICK, CL_FRAME, CL_NONE
  } etx_class_t;

  function automatic etx_class_t etx_decode(input logic par, input logic a, input logic b);
    if (a && b)            return CL_NONE;
    else if (a)            return CL_FRAME;
    else if (par && !b)    return CL_FLICK;
    else                   return CL_LINE;
  endfunction
endpackage

// File: rtl/etx_line_timer.sv
module etx_line_timer #(
  parameter int LINE_PIXELS = 780,
  parameter int SAMPLE_POS  = 34
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic tick
);
  localparam int PW = $clog2(LINE_PIXELS + 1);
  localparam logic [PW-1:0] PMAX = PW'(LINE_PIXELS);

  logic [PW-1:0] pix;

  always_ff @(posedge clk) begin
    if (!rst_n)          pix <= PMAX;
    else if (line_sync)  pix <= '0;
    else if (pix != PMAX) pix <= pix + 1'b1;
  end

  assign tick = (pix == PW'(SAMPLE_POS));
endmodule

// File: rtl/etx_fall_sampler.sv
module etx_fall_sampler #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] lvl_n,
  output logic [W-1:0] fall
);
  logic [W-1:0] held;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)    held[i] <= 1'b1;
      else if (tick) held[i] <= lvl_n[i];
    end
    assign fall[i] = tick & held[i] & ~lvl_n[i];
  end
endmodule

// File: rtl/etx_down_counter.sv
module etx_down_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] val;

  always_ff @(posedge clk) begin
    if (!rst_n)              val <= '0;
    else if (load)           val <= load_val;
    else if (dec && !last)   val <= val - 1'b1;
  end

  assign last = (val <= W'(1));
endmodule

// File: rtl/etx_trigger_ctrl.sv
module etx_trigger_ctrl #(
  parameter int LINE_PIXELS   = 780,
  parameter int SAMPLE_POS    = 34,
  parameter int FLICKER_LINES = 315,
  parameter int CNT_W         = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_sync,
  input  logic             frame_n,
  input  logic             trig_n,
  input  logic             early_n,
  input  logic             mode_a,
  input  logic             mode_b,
  input  logic             par_sel,
  input  logic             rdo_sync_sel,
  input  logic             flush_en,
  input  logic [CNT_W-1:0] exp_count,
  output logic             busy,
  output logic             xfer_req,
  output logic             flush_req,
  output logic             sub_clear
);
  import etx_pkg::*;

  localparam int FW = $clog2(FLICKER_LINES + 1);
  localparam int RW = (CNT_W > FW) ? CNT_W : FW;
  localparam int IX_TRIG  = 0;
  localparam int IX_EARLY = 1;
  localparam int IX_FRAME = 2;

  logic       tick;
  logic [2:0] fall;
  logic       cnt_last;
  logic       enter, end_evt, frame_evt;
  logic [RW-1:0] load_val;

  etx_state_t       st;
  etx_class_t       cls;
  etx_class_t       cls_d;
  logic [CNT_W-1:0] count_q;
  logic             accept;

  etx_line_timer #(.LINE_PIXELS(LINE_PIXELS), .SAMPLE_POS(SAMPLE_POS)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .tick(tick)
  );

  etx_fall_sampler #(.W(3)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .lvl_n({frame_n, early_n, trig_n}), .fall(fall)
  );

  etx_down_counter #(.W(RW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(enter), .load_val(load_val),
    .dec(end_evt), .last(cnt_last)
  );

  always_comb begin
    cls_d     = etx_decode(par_sel, mode_a, mode_b);
    accept    = (cls_d != CL_NONE) &&
                !(cls_d == CL_FRAME && exp_count == CNT_W'(1) && rdo_sync_sel);
    frame_evt = fall[IX_FRAME];
    enter     = (st == ST_PEND) &&
                ((cls == CL_FRAME) ? frame_evt : line_sync);
    end_evt   = (st == ST_EXPOSE) &&
                ((cls == CL_FRAME) ? frame_evt : line_sync);
    load_val  = (cls == CL_FLICK) ? RW'(FLICKER_LINES) : RW'(count_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cls       <= CL_LINE;
      count_q   <= '0;
      xfer_req  <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      xfer_req  <= 1'b0;
      flush_req <= 1'b0;
      unique case (st)
        ST_IDLE: if (fall[IX_TRIG] && accept) begin
          st      <= ST_PEND;
          cls     <= cls_d;
          count_q <= exp_count;
        end
        ST_PEND: if (enter) begin
          st        <= ST_EXPOSE;
          flush_req <= flush_en && (cls != CL_FRAME);
        end
        ST_EXPOSE: begin
          if (end_evt && cnt_last) begin
            xfer_req <= 1'b1;
            st       <= ST_DONE;
          end else if (fall[IX_EARLY]) begin
            if (!rdo_sync_sel) begin
              xfer_req <= 1'b1;
              st       <= ST_DONE;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        ST_HOLD: if (frame_evt) begin
          xfer_req <= 1'b1;
          st       <= ST_DONE;
        end
        ST_DONE: if (line_sync) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign sub_clear = !((st == ST_EXPOSE) || (st == ST_HOLD));
endmodule

// File: rtl/etx_trigger_ctrl_chk.sv
module etx_trigger_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic line_sync,
  input logic flush_en,
  input logic busy,
  input logic xfer_req,
  input logic flush_req,
  input logic sub_clear
);
  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> busy); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |=> !xfer_req); // R3
  AST_BUSY_FALL_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(line_sync)); // R7
  AST_FLUSH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(flush_en)); // R8
  AST_FLUSH_IN_EXPOSURE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (busy && !sub_clear)); // R11
endmodule

bind etx_trigger_ctrl etx_trigger_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .flush_en(flush_en),
  .busy(busy), .xfer_req(xfer_req), .flush_req(flush_req), .sub_clear(sub_clear)
);

// File: tb/tb_etx_trigger_ctrl.sv
module tb_etx_trigger_ctrl;
  localparam int L  = 16;
  localparam int SP = 4;
  localparam int FL = 9;
  localparam int CW = 10;
  localparam int WD = 150000;

  logic clk = 0;
  logic rst_n = 0;
  logic line_sync = 0;
  logic frame_n = 1, trig_n = 1, early_n = 1;
  logic mode_a = 0, mode_b = 1, par_sel = 0, rdo_sync_sel = 1, flush_en = 1;
  logic [CW-1:0] exp_count = 3;
  logic busy, xfer_req, flush_req, sub_clear;

  int checks = 0, errors = 0, cyc = 0, lc = 0;
  int n_x = 0, n_f = 0, saw_busy = 0;
  bit done = 0;

  etx_trigger_ctrl #(.LINE_PIXELS(L), .SAMPLE_POS(SP), .FLICKER_LINES(FL), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_n(frame_n), .trig_n(trig_n),
    .early_n(early_n), .mode_a(mode_a), .mode_b(mode_b), .par_sel(par_sel),
    .rdo_sync_sel(rdo_sync_sel), .flush_en(flush_en), .exp_count(exp_count),
    .busy(busy), .xfer_req(xfer_req), .flush_req(flush_req), .sub_clear(sub_clear)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    lc <= (lc == L - 1) ? 0 : lc + 1;
    line_sync <= (lc == L - 1);
  end

  // behavioural reference: 0 idle, 1 armed, 2 exposing, 3 waiting frame, 4 finishing
  int m_pix = L, m_st = 0, m_cls = 0, m_cnt = 0, m_n = 0;
  int m_tq = 1, m_eq = 1, m_fq = 1, m_x = 0, m_f = 0;
  always @(posedge clk) begin
    bit tk, ft, fe, ff, evt;
    int c;
    if (!rst_n) begin
      m_pix = L; m_st = 0; m_cls = 0; m_cnt = 0; m_n = 0;
      m_tq = 1; m_eq = 1; m_fq = 1; m_x = 0; m_f = 0;
    end else begin
      tk = (m_pix == SP);
      ft = tk && m_tq == 1 && !trig_n;
      fe = tk && m_eq == 1 && !early_n;
      ff = tk && m_fq == 1 && !frame_n;
      if (tk) begin m_tq = trig_n; m_eq = early_n; m_fq = frame_n; end
      if (line_sync) m_pix = 0; else if (m_pix < L) m_pix++;
      m_x = 0; m_f = 0;
      if (mode_a && mode_b) c = 3; else if (mode_a) c = 2;
      else if (par_sel && !mode_b) c = 1; else c = 0;
      evt = (m_cls == 2) ? ff : line_sync;
      case (m_st)
        0: if (ft && c != 3 && !(c == 2 && exp_count == 1 && rdo_sync_sel)) begin
             m_st = 1; m_cls = c; m_n = exp_count;
           end
        1: if (evt) begin
             m_st = 2; m_cnt = (m_cls == 1) ? FL : m_n;
             m_f = (flush_en && m_cls != 2) ? 1 : 0;
           end
        2: if (evt && m_cnt <= 1) begin m_x = 1; m_st = 4; end
           else begin
             if (evt) m_cnt--;
             if (fe) begin
               if (!rdo_sync_sel) begin m_x = 1; m_st = 4; end else m_st = 3;
             end
           end
        3: if (ff) begin m_x = 1; m_st = 4; end
        4: if (line_sync) m_st = 0;
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R7 busy", busy, m_st != 0);
    chk("R3 xfer_req", xfer_req, m_x);
    chk("R8 flush_req", flush_req, m_f);
    chk("R11 sub_clear", sub_clear, !(m_st == 2 || m_st == 3));
    if (xfer_req) n_x++;
    if (flush_req) n_f++;
    if (busy) saw_busy = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      errors++; checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic next_line();
    @(posedge clk);
    while (!line_sync) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_pulse();
    next_line(); trig_n = 0; next_line(); trig_n = 1;
  endtask

  task automatic frame_pulse();
    next_line(); frame_n = 0; next_line(); frame_n = 1;
  endtask

  task automatic early_pulse();
    next_line(); early_n = 0; next_line(); early_n = 1;
  endtask

  task automatic settle();
    repeat (2) next_line();
    while (busy) next_line();
    repeat (2) next_line();
  endtask

  task automatic scn_begin();
    n_x = 0; n_f = 0; saw_busy = 0;
  endtask

  task automatic scn_end(input string tag, input int ex, input int ef, input int eb);
    chk({tag, " strobes"}, n_x, ex);
    chk({tag, " discharges"}, n_f, ef);
    chk({tag, " busy seen"}, saw_busy, eb);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 xfer_req", xfer_req, 0);
    chk("R1 flush_req", flush_req, 0);
    chk("R1 sub_clear", sub_clear, 1);
    rst_n = 1;
    repeat (2) next_line();

    // R3 serial line mode, N = 3, discharge on
    scn_begin(); trig_pulse(); settle(); scn_end("R3 serial", 1, 1, 1);

    // R2 glitch between sample points
    scn_begin(); next_line(); repeat (6) @(negedge clk); trig_n = 0;
    repeat (2) @(negedge clk); trig_n = 1; settle(); scn_end("R2 glitch", 0, 0, 0);

    // R3 parallel line mode, N = 2, discharge off; also N = 0
    par_sel = 1; mode_b = 1; exp_count = 2; flush_en = 0;
    scn_begin(); trig_pulse(); settle(); scn_end("R3 parallel", 1, 0, 1);
    exp_count = 0;
    scn_begin(); trig_pulse(); settle(); scn_end("R3 zero count", 1, 0, 1);

    // R4 flicker mode
    mode_b = 0; flush_en = 1;
    scn_begin(); trig_pulse(); settle(); scn_end("R4 flicker", 1, 1, 1);

    // R6 ignored mode
    mode_a = 1; mode_b = 1;
    scn_begin(); trig_pulse(); settle(); scn_end("R6 ignore", 0, 0, 0);

    // R5 frame mode N = 2, discharge enable has no effect (R8)
    mode_b = 0; exp_count = 2;
    scn_begin(); trig_pulse();
    repeat (4) begin frame_pulse(); next_line(); end
    settle(); scn_end("R5 frame", 1, 0, 1);

    // R10 frame count 1 with frame-synced readout: no entry, then entry with it low
    exp_count = 1; rdo_sync_sel = 1;
    scn_begin(); trig_pulse(); frame_pulse(); settle(); scn_end("R10 blocked", 0, 0, 0);
    rdo_sync_sel = 0;
    scn_begin(); trig_pulse();
    repeat (3) begin frame_pulse(); next_line(); end
    settle(); scn_end("R10 allowed", 1, 0, 1);

    // R9 early readout, immediate
    mode_a = 0; mode_b = 1; par_sel = 0; exp_count = 20; rdo_sync_sel = 0;
    scn_begin(); trig_pulse(); repeat (3) next_line(); early_pulse();
    chk("R9 early strobe", n_x, 1);
    early_pulse(); settle(); scn_end("R9 immediate", 1, 1, 1);

    // R9 early readout waiting for a frame event; second edge ignored
    rdo_sync_sel = 1;
    scn_begin(); trig_pulse(); repeat (3) next_line(); early_pulse();
    chk("R9 held", n_x, 0);
    early_pulse(); frame_pulse(); next_line();
    chk("R9 frame strobe", n_x, 1);
    settle(); scn_end("R9 frame sync", 1, 1, 1);

    // R9 early edge outside trigger mode
    scn_begin(); early_pulse(); settle(); scn_end("R9 idle", 0, 0, 0);

    // R7 trigger while busy is ignored
    exp_count = 6;
    scn_begin(); trig_pulse(); next_line(); trig_pulse(); settle();
    scn_end("R7 retrigger", 1, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule